// File: doc/BRIEF.md
# Looping Eight-Sample DAC Pattern Generator

This block sits in front of a two-channel DAC and can replace the live transmit samples with a short test pattern. Each channel keeps its own bank of eight 12-bit samples. The banks are loaded through a byte-wide register write port. Each channel also has its own loop-enable control. While a channel's enable is high, that channel plays its eight samples in order, one per DAC clock, and then starts again at the first sample, for as long as the enable stays high. While the enable is low, the channel forwards its live input instead.

The design runs entirely in the DAC clock domain. Live samples enter on one flattened bus and DAC samples leave on another, one word per channel per clock. The DAC takes a word on every clock, so the streams have no valid/ready handshake and no back-pressure. Both output paths, pattern and live, pass through the same single register stage. Switching a channel between the two sources therefore never changes its latency.

Top module: `dac_loop_pattern`

## Requirements
- R1: After reset every output sample is 0 and every stored pattern sample is 0.
- R2: On the first clock edge at which a channel's enable is sampled high after being low (or after reset), that channel outputs pattern entry 0.
- R3: While the enable stays high, the channel outputs entries 1, 2, … 7 on successive clocks and then wraps to entry 0 without end.
- R4: Channel A pattern bytes live at byte addresses 0x11F to 0x12E and channel B at 0x12F to 0x13E. A write to any other address changes no stored sample.
- R5: Entry k of a channel uses the byte address base+2k for bits 7:0 and base+2k+1 for bits 11:8. Bits 11:8 come from data bits 3:0, and data bits 7:4 of that high-byte write are ignored.
- R6: A write to a low-byte address only stages that byte. The entry visible at the output changes only when its high byte is written, and then both bytes change together.
- R7: While a channel's enable is low, its output on each clock equals its live input sampled on the previous clock (one register of latency).
- R8: The two channels are independent. Enables, indices and stored samples of one channel never affect the other.
- R9: A pattern write that completes while its channel is playing is used the next time that entry's index is output. A high-byte write on the same edge as the entry's readout leaves that readout at the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_data | input | 8 | Register byte write data |
| loop_en | input | 2 | Per-channel pattern enable, bit 0 channel A, bit 1 channel B |
| live_in | input | 24 | Live samples, bits 11:0 channel A, bits 23:12 channel B |
| dac_out | output | 24 | DAC samples, bits 11:0 channel A, bits 23:12 channel B |

## Verification
Several properties are checked on every cycle by assertions in the RTL:
- the playback index returns to zero while a channel is disabled;
- the index steps by one and wraps after entry 7 while the channel is enabled;
- a disabled channel's output repeats the previous live sample;
- a low-byte-only write leaves the committed bank untouched;
- no address selects both channels.

Other behaviours need the bench's scenarios, because they depend on the contents and order of whole sequences:
- the byte packing and the ignored upper nibble;
- the exact address window edges;
- the sample value played on the first enabled cycle;
- the timing of writes made during playback;
- isolation between the two channels.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  // Which half of a sample a byte write targets
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } byte_half_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/dlp_wr_decode.sv
module dlp_wr_decode
  import dlp_pkg::*;
#(
  parameter int unsigned AW    = 9,
  parameter int unsigned NCH   = 2,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BASE  = 'h11F,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned SPAN = 2 * DEPTH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  output logic [NCH-1:0] ch_sel,
  output logic [IW-1:0]  slot,
  output byte_half_e     half
);
  localparam int unsigned OW = $clog2(SPAN);

  logic [AW:0] rel;
  logic [AW:0] base_w;

  assign base_w = (AW+1)'(BASE);
  assign rel    = {1'b0, addr} - base_w;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_win
      localparam int unsigned LO = BASE + c * SPAN;
      logic [AW:0] a_w;
      assign a_w = {1'b0, addr};
      assign ch_sel[c] = wr && (a_w >= (AW+1)'(LO)) && (a_w < (AW+1)'(LO + SPAN));
    end
  endgenerate

  logic [OW-1:0] off;
  assign off  = rel[OW-1:0];
  assign slot = off[OW-1:1];
  assign half = off[0] ? HALF_HI : HALF_LO;

  // An address may fall in at most one channel window
  assert_one_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));
endmodule

// File: rtl/dlp_sample_bank.sv
module dlp_sample_bank
  import dlp_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SW    = 12,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned HW   = SW - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IW-1:0]     slot,
  input  byte_half_e        half,
  input  logic [BYTE_W-1:0] data,
  input  logic [IW-1:0]     rd_idx,
  output logic [SW-1:0]     rd_data
);
  logic [DEPTH-1:0][BYTE_W-1:0] stage_q;
  logic [DEPTH-1:0][SW-1:0]     mem_q;

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_ent
      logic hit;
      assign hit = wr && (slot == IW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[k] <= '0;
          mem_q[k]   <= '0;
        end else if (hit) begin
          if (half == HALF_LO) stage_q[k] <= data;
          else                 mem_q[k]   <= {data[HW-1:0], stage_q[k]};
        end
      end
    end
  endgenerate

  assign rd_data = mem_q[rd_idx];

  // Staging a low byte alone must never alter a committed sample
  assert_lo_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && half == HALF_LO) |=> $stable(mem_q));
endmodule

// File: rtl/dlp_play_index.sv
module dlp_play_index #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx <= '0;
    else if (!en)        idx <= '0;
    else if (idx == LAST) idx <= '0;
    else                 idx <= idx + 1'b1;
  end

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> idx == '0);
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && idx == LAST) |=> idx == '0);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && idx != LAST) |=> idx == IW'($past(idx) + 1'b1));
endmodule

// File: rtl/dlp_out_stage.sv
module dlp_out_stage #(
  parameter int unsigned SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [SW-1:0] pat,
  input  logic [SW-1:0] live,
  output logic [SW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= en ? pat : live;
  end

  assert_live_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> q == $past(live));
endmodule

// File: rtl/dac_loop_pattern.sv
module dac_loop_pattern
  import dlp_pkg::*;
#(
  parameter int unsigned NCH   = 2,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SW    = 12,
  parameter int unsigned AW    = 9,
  parameter int unsigned BASE  = 'h11F,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_data,
  input  logic [NCH-1:0]    loop_en,
  input  logic [NCH*SW-1:0] live_in,
  output logic [NCH*SW-1:0] dac_out
);
  logic [NCH-1:0] ch_sel;
  logic [IW-1:0]  wr_slot;
  byte_half_e     wr_half;

  dlp_wr_decode #(
    .AW(AW), .NCH(NCH), .DEPTH(DEPTH), .BASE(BASE)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .ch_sel(ch_sel), .slot(wr_slot), .half(wr_half)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic [IW-1:0] idx;
      logic [SW-1:0] pat;

      dlp_play_index #(.DEPTH(DEPTH)) u_idx (
        .clk(clk), .rst_n(rst_n), .en(loop_en[c]), .idx(idx)
      );

      dlp_sample_bank #(.DEPTH(DEPTH), .SW(SW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(ch_sel[c]), .slot(wr_slot),
        .half(wr_half), .data(reg_data), .rd_idx(idx), .rd_data(pat)
      );

      dlp_out_stage #(.SW(SW)) u_out (
        .clk(clk), .rst_n(rst_n), .en(loop_en[c]), .pat(pat),
        .live(live_in[c*SW +: SW]), .q(dac_out[c*SW +: SW])
      );
    end
  endgenerate
endmodule

// File: tb/dac_loop_pattern_test.sv
module dac_loop_pattern_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [7:0]  reg_data = '0;
  logic [1:0]  loop_en = '0;
  logic [23:0] live_in = '0;
  logic [23:0] dac_out;

  dac_loop_pattern uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_data(reg_data), .loop_en(loop_en), .live_in(live_in), .dac_out(dac_out)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int ref_bank [2][8];
  int ref_stage[2][8];
  int ref_idx  [2];
  int exp_out  [2];

  function automatic int base_of(int ch);
    return 'h11F + ch * 16;
  endfunction

  task automatic check(string tag, int ch, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s ch%0d actual=%03h expected=%03h", tag, ch, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model, check after posedge.
  task automatic step(string tag, bit w, int a, int d, bit [1:0] en, int la, int lb);
    int lv[2];
    reg_wr = w; reg_addr = a[8:0]; reg_data = d[7:0];
    loop_en = en; live_in = {lb[11:0], la[11:0]};
    lv[0] = la & 'hFFF; lv[1] = lb & 'hFFF;
    for (int c = 0; c < 2; c++) begin
      if (en[c]) begin
        exp_out[c] = ref_bank[c][ref_idx[c]];
        ref_idx[c] = (ref_idx[c] + 1) % 8;
      end else begin
        exp_out[c] = lv[c];
        ref_idx[c] = 0;
      end
    end
    if (w && a >= 'h11F && a <= 'h13E) begin
      int ch, off, sl;
      ch = (a - 'h11F) / 16; off = (a - 'h11F) % 16; sl = off / 2;
      if (off % 2 == 1) ref_bank[ch][sl] = ((d & 'hF) << 8) | ref_stage[ch][sl];
      else              ref_stage[ch][sl] = d & 'hFF;
    end
    @(posedge clk); #2;
    check(tag, 0, int'(dac_out[11:0]),  exp_out[0]);
    check(tag, 1, int'(dac_out[23:12]), exp_out[1]);
    @(negedge clk);
  endtask

  task automatic wr_sample(string tag, int ch, int sl, int val, bit [1:0] en);
    step(tag, 1, base_of(ch) + 2*sl,     val & 'hFF, en, 0, 0);
    step(tag, 1, base_of(ch) + 2*sl + 1, ($urandom & 'hF0) | ((val >> 8) & 'hF), en, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < 2; c++) begin
      ref_idx[c] = 0;
      for (int k = 0; k < 8; k++) begin ref_bank[c][k] = 0; ref_stage[c][k] = 0; end
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 0, int'(dac_out[11:0]), 0);
    check("R1", 1, int'(dac_out[23:12]), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: enabled right after reset plays zero bank
    for (int i = 0; i < 3; i++) step("R1", 0, 0, 0, 2'b11, 0, 0);
    step("R2", 0, 0, 0, 2'b00, 0, 0);

    // R5: load both banks with noisy upper nibble
    for (int k = 0; k < 8; k++) wr_sample("R5", 0, k, 'h100 * (k + 1) + 'h10 + k, 2'b00);
    for (int k = 0; k < 8; k++) wr_sample("R5", 1, k, 'hA00 + 'h11 * k, 2'b00);

    // R6: low byte only on A entry 0, then play A with B live (R7, R8)
    step("R6", 1, 'h11F, 'hEE, 2'b00, 0, 0);
    for (int i = 0; i < 20; i++)
      step("R3", 0, 0, 0, 2'b01, $urandom, $urandom);
    // R6: commit entry 0 high byte during playback (R9)
    step("R9", 1, 'h120, 'h05, 2'b01, 0, 0);
    for (int i = 0; i < 10; i++) step("R9", 0, 0, 0, 2'b01, 0, $urandom);

    // R4: window edges, out-of-range writes
    step("R4", 1, 'h11E, 'h77, 2'b00, 1, 2);
    step("R4", 1, 'h13F, 'h0F, 2'b00, 3, 4);
    step("R4", 1, 'h100, 'h0F, 2'b00, 5, 6);
    step("R4", 1, 'h13E, 'h0C, 2'b00, 7, 8);  // top of B: entry 7 high
    step("R4", 1, 'h12E, 'h09, 2'b00, 7, 8);  // top of A: entry 7 high
    for (int i = 0; i < 9; i++) step("R4", 0, 0, 0, 2'b11, 0, 0);

    // R2: restart from entry 0 mid-sequence
    step("R2", 0, 0, 0, 2'b10, 0, 0);
    for (int i = 0; i < 4; i++) step("R2", 0, 0, 0, 2'b11, 0, 0);

    // R8: B plays while A toggles
    for (int i = 0; i < 12; i++) step("R8", 0, 0, 0, {1'b1, i[1]}, $urandom, 0);

    // Random phase
    begin
      bit [1:0] en = 2'b00;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom % 16 == 0) en[0] = ~en[0];
        if ($urandom % 16 == 0) en[1] = ~en[1];
        if ($urandom % 3 == 0)
          step("R3", 1, 'h110 + ($urandom % 64), $urandom, en, $urandom, $urandom);
        else
          step("R7", 0, 0, 0, en, $urandom, $urandom);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule